// File: doc/BRIEF.md
# Receive Frame Status and Readout

This block is the host-facing read side of a receive path. A receive MAC hands it a stream of bytes, one per cycle, with a marker on the final byte of each frame and a classification byte that arrives with that final byte. The block keeps two internal queues. A per-frame status queue records each frame's byte count, done flag and classification. A byte queue holds the frame payload.

The host sees two words. The status word always describes the frame at the head of the status queue. Its byte count climbs while the frame is still arriving. Once the last byte is in, the done flag is set and the fields stop changing. Reading the status word while the done flag is set retires that entry, so the next status read describes the following frame, whatever payload of the earlier frame is still unread. The data word delivers payload up to four bytes per read. A read never crosses into the next frame, and unused byte lanes read as zero.

Both host words reflect the registered state. A read strobe is taken on the clock edge, and its effect shows in the next cycle. Both depth parameters must be powers of two, and the byte queue must be at least four entries deep.

Top module: `rx_frame_readout`

## Requirements
- R1: `stat_word[15:0]` holds the number of bytes accepted so far for the head frame. Each accepted byte of that frame raises it by one in the next cycle, including bytes that arrive before the frame is complete.
- R2: When the status queue holds no frame, `stat_word` is all zero. A count of zero therefore means no frame is present.
- R3: Data reads never change the byte count. After all of a frame's payload has been read, the count still equals the frame size.
- R4: `stat_word[31]` (done) becomes 1 in the cycle after the byte carrying `rx_last` is accepted. `stat_word[23:16]` takes `rx_class` from that same byte and reads zero before it. Bits [30:24] are zero. Once done is set, the count and class no longer change.
- R5: A `stat_rd` pulse while done is set removes the head entry, and the next cycle shows the next frame (or zero). A `stat_rd` pulse while done is clear has no effect.
- R6: `data_word` presents up to four of the oldest unread bytes and stops after a frame's last byte. If a frame has only partly arrived, it presents only the bytes present so far. Unfilled byte lanes are zero. A `data_rd` pulse removes exactly the bytes presented.
- R7: Within `data_word`, the oldest byte sits in bits [7:0], the next in [15:8], then [23:16], then [31:24].
- R8: With no payload buffered, `data_word` is zero, and a `data_rd` pulse changes nothing.
- R9: `rx_ready` is 0 when the byte queue is full, or when no frame is open and the status queue is full. A byte offered while `rx_ready` is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte value |
| rx_last | input | 1 | Offered byte ends its frame |
| rx_class | input | 8 | Classification of the frame, sampled with the last byte |
| rx_ready | output | 1 | The offered byte is accepted on this edge |
| stat_rd | input | 1 | Host reads the status word |
| stat_word | output | 32 | Head frame status: done, class, byte count |
| data_rd | input | 1 | Host reads the data word |
| data_word | output | 32 | Next up-to-four payload bytes, zero padded |

## Verification
The bench targets four places where the status and payload sides can disagree. The first is a status read on a frame that is still arriving; a design that pops on any read would lose the entry and desynchronise the queues. The second is a status read that retires a done frame while its payload is still unread; a design that ties the two queues together would stall or show the wrong frame. The third is a frame whose length is not a multiple of four; a design that ignores frame boundaries would leak the next frame's first bytes into the padded lanes. The last covers reads from an empty byte queue and writes while the queues are full; a design with weak pointer guards would wrap its occupancy and replay stale bytes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int CNT_W = 16;
    localparam int CLS_W = 8;
    localparam int WORD_W = 32;
    localparam int LANES = WORD_W / 8;

    typedef struct packed {
        logic             done;
        logic [CLS_W-1:0] cls;
        logic [CNT_W-1:0] cnt;
    } stat_ent_t;

    localparam int PAD_W = WORD_W - 1 - CLS_W - CNT_W;
endpackage

// File: rtl/rxr_stat_fifo.sv
module rxr_stat_fifo
    import rxr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_last,
    input  logic [CLS_W-1:0]  push_cls,
    input  logic              pop_req,
    output logic [WORD_W-1:0] head_word,
    output logic              has_space,
    output logic              frame_open
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        stat_ent_t [DEPTH-1:0] ent;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [AW:0]           occ;
        logic                  open;
    } st_t;

    st_t st_q, st_d;
    stat_ent_t head;
    logic head_done, pop, push_new;
    logic [AW-1:0] last_idx;

    always_comb begin
        head      = (st_q.occ != '0) ? st_q.ent[st_q.rd] : '0;
        head_done = (st_q.occ != '0) && head.done;
        pop       = pop_req && head_done;
        push_new  = push && !st_q.open;
        last_idx  = st_q.wr - 1'b1;
        st_d      = st_q;
        if (pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        if (push) begin
            if (!st_q.open) begin
                st_d.ent[st_q.wr].done = push_last;
                st_d.ent[st_q.wr].cls  = push_last ? push_cls : '0;
                st_d.ent[st_q.wr].cnt  = CNT_W'(1);
                st_d.wr                = st_q.wr + 1'b1;
            end else begin
                st_d.ent[last_idx].cnt = st_q.ent[last_idx].cnt + 1'b1;
                if (push_last) begin
                    st_d.ent[last_idx].done = 1'b1;
                    st_d.ent[last_idx].cls  = push_cls;
                end
            end
            st_d.open = !push_last;
        end
        st_d.occ = st_q.occ + (AW+1)'(push_new) - (AW+1)'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_word  = {head.done, {PAD_W{1'b0}}, head.cls, head.cnt};
    assign has_space  = st_q.occ < (AW+1)'(DEPTH);
    assign frame_open = st_q.open;

    assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= (AW+1)'(DEPTH));
    assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.occ != '0 && !pop) |=> (head.cnt >= $past(head.cnt)));
    assert_done_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_done && !pop_req) |=> (head.done && $stable(head.cnt) && $stable(head.cls)));
    assert_pop_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_new) |=> (st_q.occ == $past(st_q.occ) - 1'b1));
endmodule

// File: rtl/rxr_byte_fifo.sv
module rxr_byte_fifo
    import rxr_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              has_space
);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(LANES) + 1;

    typedef struct packed {
        logic [DEPTH-1:0][8:0] mem;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [AW:0]           occ;
    } bf_t;

    bf_t bf_q, bf_d;
    logic [WORD_W-1:0] word;
    logic [TW-1:0] take;
    logic stop, do_wr;
    logic [AW-1:0] idx;

    always_comb begin
        word = '0;
        take = '0;
        stop = 1'b0;
        idx  = '0;
        for (int i = 0; i < LANES; i++) begin
            idx = bf_q.rd + AW'(i);
            if (!stop && ((AW+1)'(i) < bf_q.occ)) begin
                word[8*i +: 8] = bf_q.mem[idx][7:0];
                take           = take + 1'b1;
                stop           = bf_q.mem[idx][8];
            end
        end
        do_wr = wr_en && (bf_q.occ < (AW+1)'(DEPTH));
        bf_d  = bf_q;
        if (do_wr) begin
            bf_d.mem[bf_q.wr] = {wr_last, wr_byte};
            bf_d.wr           = bf_q.wr + 1'b1;
        end
        if (rd_en) begin
            bf_d.rd = bf_q.rd + AW'(take);
        end
        bf_d.occ = bf_q.occ + (AW+1)'(do_wr) - (rd_en ? (AW+1)'(take) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bf_q <= '0;
        else        bf_q <= bf_d;
    end

    assign rd_word   = word;
    assign has_space = bf_q.occ < (AW+1)'(DEPTH);

    assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bf_q.occ <= (AW+1)'(DEPTH));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bf_q.occ == '0 && !wr_en) |=> (bf_q.occ == '0));
    assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bf_q.occ == '0) |-> (rd_word == '0));
endmodule

// File: rtl/rx_frame_readout.sv
module rx_frame_readout
    import rxr_pkg::*;
#(
    parameter int BYTE_DEPTH = 64,
    parameter int STAT_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    input  logic [CLS_W-1:0]  rx_class,
    output logic              rx_ready,
    input  logic              stat_rd,
    output logic [WORD_W-1:0] stat_word,
    input  logic              data_rd,
    output logic [WORD_W-1:0] data_word
);
    logic byte_space, stat_space, open, accept;

    always_comb begin
        rx_ready = byte_space && (open || stat_space);
        accept   = rx_valid && rx_ready;
    end

    rxr_stat_fifo #(.DEPTH(STAT_DEPTH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_last  (rx_last),
        .push_cls   (rx_class),
        .pop_req    (stat_rd),
        .head_word  (stat_word),
        .has_space  (stat_space),
        .frame_open (open)
    );

    rxr_byte_fifo #(.DEPTH(BYTE_DEPTH)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_byte   (rx_byte),
        .wr_last   (rx_last),
        .rd_en     (data_rd),
        .rd_word   (data_word),
        .has_space (byte_space)
    );

    assert_ready_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_space) |-> !rx_ready);
endmodule

// File: tb/rx_frame_readout_tb.sv
module rx_frame_readout_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BD = 64;
    localparam int SD = 8;
    localparam int WATCHDOG_CYCLES = 150000;

    typedef struct {
        int         cnt;
        bit         done;
        logic [7:0] cls;
    } ment_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_last = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_byte = '0, rx_class = '0;
    logic rx_ready;
    logic [31:0] stat_word, data_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    ment_t sq[$];
    logic [8:0] bq[$];
    bit open_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_readout #(.BYTE_DEPTH(BD), .STAT_DEPTH(SD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_class(rx_class),
        .rx_ready(rx_ready),
        .stat_rd(stat_rd), .stat_word(stat_word),
        .data_rd(data_rd), .data_word(data_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        if (sq.size() == 0) return 32'h0;
        return {sq[0].done, 7'b0, sq[0].cls, sq[0].cnt[15:0]};
    endfunction

    function automatic int exp_take(output logic [31:0] w);
        int t = 0;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            if (i >= bq.size()) break;
            w[8*i +: 8] = bq[i][7:0];
            t++;
            if (bq[i][8]) break;
        end
        return t;
    endfunction

    function automatic bit model_ready();
        return (bq.size() < BD) && (open_m || sq.size() < SD);
    endfunction

    task automatic compare_all();
        logic [31:0] w;
        int t;
        t = exp_take(w);
        check(sq.size() == 0 ? "R2" : (sq[0].done ? "R4" : "R1"), stat_word, exp_stat());
        check(bq.size() == 0 ? "R8" : "R6", data_word, w);
        check("R9", {31'b0, rx_ready}, {31'b0, model_ready()});
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit l, input logic [7:0] c,
                        input bit sr, input bit dr, output bit acc);
        logic [31:0] w;
        int t;
        compare_all();
        rx_valid = v; rx_byte = b; rx_last = l; rx_class = c;
        stat_rd = sr; data_rd = dr;
        acc = v && model_ready();
        t = exp_take(w);
        if (sr && sq.size() > 0 && sq[0].done) void'(sq.pop_front());
        if (dr) for (int i = 0; i < t; i++) void'(bq.pop_front());
        if (acc) begin
            bq.push_back({l, b});
            if (!open_m) begin
                sq.push_back('{cnt: 1, done: l, cls: (l ? c : 8'h00)});
            end else begin
                sq[sq.size()-1].cnt++;
                if (l) begin
                    sq[sq.size()-1].done = 1'b1;
                    sq[sq.size()-1].cls  = c;
                end
            end
            open_m = !l;
        end
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0; stat_rd = 1'b0; data_rd = 1'b0; rx_last = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base, input logic [7:0] c);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b1, base + 8'(i), i == n-1, c, 1'b0, 1'b0, acc);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit acc;
        int rem;
        logic [7:0] cls_cur;
        int pv, pr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R2 R8 R9
        check("R2", stat_word, 32'h0);
        check("R8", data_word, 32'h0);
        check("R9", {31'b0, rx_ready}, 32'h1);
        // empty data read has no effect (R8)
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b1, acc);
        check("R8", data_word, 32'h0);
        // live count before done (R1), status read on open frame ignored (R5)
        step(1'b1, 8'h11, 1'b0, 8'h77, 1'b0, 1'b0, acc);
        step(1'b1, 8'h12, 1'b0, 8'h77, 1'b1, 1'b0, acc);
        check("R1", stat_word, 32'h0000_0002);
        send_frame(3, 8'h13, 8'h5A);
        check("R4", stat_word, 32'h805A_0005);
        check("R7", data_word, 32'h1413_1211);
        send_frame(3, 8'h21, 8'h33);
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b1, acc);
        check("R6", data_word, 32'h0000_0015);
        check("R3", stat_word, 32'h805A_0005);
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 1'b0, acc);
        check("R5", stat_word, 32'h8033_0003);
        check("R6", data_word, 32'h0000_0015);
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b1, acc);
        check("R6", data_word, 32'h0023_2221);
        check("R5", stat_word, 32'h8033_0003);
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b0, 1'b1, acc);
        check("R3", stat_word, 32'h8033_0003);
        step(1'b0, 8'h0, 1'b0, 8'h0, 1'b1, 1'b0, acc);
        check("R2", stat_word, 32'h0);
        // randomised phases: fill-heavy, drain-heavy, mixed
        rem = 0;
        cls_cur = 8'h0;
        for (int ph = 0; ph < 3; ph++) begin
            pv = (ph == 0) ? 90 : (ph == 1) ? 30 : 65;
            pr = (ph == 0) ? 8 : (ph == 1) ? 80 : 40;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                bit v, sr, dr;
                logic [7:0] b;
                if (rem == 0) begin
                    rem = $urandom_range(1, 11);
                    cls_cur = 8'($urandom);
                end
                v  = $urandom_range(99) < pv;
                sr = $urandom_range(99) < pr;
                dr = $urandom_range(99) < pr;
                b  = 8'($urandom);
                step(v, b, rem == 1, cls_cur, sr, dr, acc);
                if (acc) rem--;
            end
        end
        compare_all();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule